// File: doc/BRIEF.md
# Status Alarm Alert Controller

This block keeps the four status and alarm bytes of a power-supply management slave and drives its active-low alert line toward the host. It receives two kinds of input. The first is live fault levels from the monitoring logic: input or output out of limits, overvoltage, overcurrent, overtemperature warning and shutdown, power limit, fan fault and internal fault. The second is single-cycle event pulses from the command receiver: checksum error, unsupported command, out-of-range data, restart completed, clear-faults, status read completed and output recycled. Every flag is sticky. A flag stays set until the host clears it, and a live condition that is still present sets its flag again one cycle after a clear.

The alert is raised by any change in the register image, not by a chosen list of faults. The image is compared with a snapshot taken at the last host clear, read or output recycle. A fault that stays steady therefore raises the alert once for each clear. A completed status read wipes the flags but keeps the communication-error flags, which only clear-faults removes. The data-range flag also survives clear-faults while the out-of-range condition still holds. The four bytes are always present on the outputs for the read logic to serialise.

Top module: `sa_alert_ctrl`

## Requirements
- R1: After reset all four register bytes read 0 and alert_n_o is 1.
- R2: alm_live_i bit n sets alm1_o bit n one clock later, for n = 0 input out of limits, 1 output out of limits, 2 overvoltage shutdown, 3 overcurrent shutdown, 4 overtemperature warning, 5 overtemperature shutdown, 7 power limit. The bit stays set after the input drops until it is cleared. alm_live_i bit 6 is ignored and alm1_o bit 6 is always 0.
- R3: sts2_o bits are: 7 checksum error (pec_err_i pulse), 6 will restart (will_restart_i level), 5 invalid command (bad_cmd_i pulse), 3 isolation test failed (iso_fail_i level), 2 restarted ok (restart_ok_i pulse), 1 data out of range (oor_set_i pulse), 0 enable pin high (en_pin_hi_i level). Bit 4 is always 0. Each bit sets one clock after its input, and 1 means alarm.
- R4: sts1_o bit 0 latches int_fault_i and alm2_o bit 0 latches fan_fault_i. All other bits of these two bytes are always 0.
- R5: When any register bit changes in a cycle with no host event (clear, read or recycle), alert_n_o goes low one clock later and stays low until it is released.
- R6: A cycle with clr_faults_i, read_done_i or recycle_i high sets alert_n_o high one clock later.
- R7: The register changes caused by a host event do not by themselves pull alert_n_o low.
- R8: If a live condition is still present at a clear, its bit reads 0 in the clock after the clear and 1 in the clock after that. alert_n_o goes low in the clock after that.
- R9: read_done_i clears every flag except sts2_o bits 7, 5 and 1.
- R10: clr_faults_i clears every flag, including sts2_o bits 7 and 5. sts2_o bit 1 is kept while oor_hold_i is high.
- R11: recycle_i releases the alert and leaves all four register bytes unchanged.
- R12: An event pulse that arrives in the same cycle as a clear or a read is still recorded. Live inputs are not sampled in a clear or read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alm_live_i | input | 8 | Live alarm levels, one per alarm-1 bit position |
| fan_fault_i | input | 1 | Live fan fault level |
| int_fault_i | input | 1 | Live internal fault level |
| will_restart_i | input | 1 | Live level: a restart is pending |
| iso_fail_i | input | 1 | Live level: isolation test failed |
| en_pin_hi_i | input | 1 | Live level of the enable pin (1 = off) |
| pec_err_i | input | 1 | Pulse: checksum mismatch |
| bad_cmd_i | input | 1 | Pulse: unsupported command |
| oor_set_i | input | 1 | Pulse: written data out of range |
| oor_hold_i | input | 1 | Level: out-of-range condition still holds |
| restart_ok_i | input | 1 | Pulse: restart completed |
| clr_faults_i | input | 1 | Pulse: clear-faults command |
| read_done_i | input | 1 | Pulse: status read completed |
| recycle_i | input | 1 | Pulse: output switched off then on |
| alert_n_o | output | 1 | Active-low alert |
| sts2_o | output | 8 | Status byte 2 |
| sts1_o | output | 8 | Status byte 1 |
| alm2_o | output | 8 | Alarm byte 2 |
| alm1_o | output | 8 | Alarm byte 1 |

## Verification
A stuck or wrongly updated flag is visible on the register bytes at the first negative edge after the clock edge that should have changed it, so errors in flag handling show up within one cycle. A stale or corrupted snapshot shows up differently: the alert either fails to drop one clock after a new flag appears, or drops right after a host clear with no live fault present. Either case is caught in the cycle that follows the event. Wrong keep rules on read or clear leave communication or data-range bits at the wrong value in the first byte sampled after the host pulse.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int IMG_W     = BYTE_W * NUM_BYTES;

  // status-2 bit positions
  localparam int B_PEC   = 7;
  localparam int B_WILL  = 6;
  localparam int B_INV   = 5;
  localparam int B_ISO   = 3;
  localparam int B_RSTOK = 2;
  localparam int B_OOR   = 1;
  localparam int B_ENHI  = 0;

  localparam logic [BYTE_W-1:0] S2_LIVE_MASK = 8'h49;
  localparam logic [BYTE_W-1:0] S2_RD_KEEP   = 8'hA2;
  localparam logic [BYTE_W-1:0] S2_HOLD_MASK = 8'h02;
  localparam logic [BYTE_W-1:0] A1_LIVE_MASK = 8'hBF;
  localparam logic [BYTE_W-1:0] LOW_BIT_MASK = 8'h01;

  typedef struct packed {
    logic [BYTE_W-1:0] s2;
    logic [BYTE_W-1:0] s1;
    logic [BYTE_W-1:0] a2;
    logic [BYTE_W-1:0] a1;
  } img_t;
endpackage

// File: rtl/sa_rst_sync.sv
module sa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/sa_flag_bank.sv
module sa_flag_bank #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   LIVE_MASK = '0,
  parameter logic [W-1:0]   RD_KEEP   = '0,
  parameter logic [W-1:0]   HOLD_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic         rd_i,
  input  logic         hold_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] d_c;
  logic         host;
  logic         upd_en;

  assign host   = clr_i | rd_i;
  assign upd_en = host | (|set_i) | (|(live_i & LIVE_MASK));

  // one sticky flag per bit, keep rules picked by the masks
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic wipe;
    assign wipe   = (rd_i & ~RD_KEEP[i]) | (clr_i & ~(HOLD_MASK[i] & hold_i));
    assign d_c[i] = (q_r[i] & ~wipe) | set_i[i] | (~host & live_i[i] & LIVE_MASK[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (upd_en) q_r <= d_c;
  end

  assign q_o = q_r;
  assign d_o = d_c;
endmodule

// File: rtl/sa_change_det.sv
module sa_change_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] img_i,
  input  logic [W-1:0] img_d_i,
  input  logic         host_i,
  output logic         alert_o
);
  logic [W-1:0] snap_q;
  logic         alert_q;
  logic         alert_d;

  always_comb begin
    if (host_i) alert_d = 1'b0;
    else        alert_d = alert_q | (img_i != snap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (host_i) snap_q <= img_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert_o = alert_q;
endmodule

// File: rtl/sa_alert_ctrl.sv
module sa_alert_ctrl
  import sa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] alm_live_i,
  input  logic              fan_fault_i,
  input  logic              int_fault_i,
  input  logic              will_restart_i,
  input  logic              iso_fail_i,
  input  logic              en_pin_hi_i,
  input  logic              pec_err_i,
  input  logic              bad_cmd_i,
  input  logic              oor_set_i,
  input  logic              oor_hold_i,
  input  logic              restart_ok_i,
  input  logic              clr_faults_i,
  input  logic              read_done_i,
  input  logic              recycle_i,
  output logic              alert_n_o,
  output logic [BYTE_W-1:0] sts2_o,
  output logic [BYTE_W-1:0] sts1_o,
  output logic [BYTE_W-1:0] alm2_o,
  output logic [BYTE_W-1:0] alm1_o
);
  logic              rst_s;
  logic              host_any;
  logic              alert_q;
  img_t              img_q;
  img_t              img_d;
  logic [BYTE_W-1:0] s2_live, s2_set, s1_live, a2_live;

  sa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s)
  );

  always_comb begin
    s2_live          = '0;
    s2_live[B_WILL]  = will_restart_i;
    s2_live[B_ISO]   = iso_fail_i;
    s2_live[B_ENHI]  = en_pin_hi_i;
    s2_set           = '0;
    s2_set[B_PEC]    = pec_err_i;
    s2_set[B_INV]    = bad_cmd_i;
    s2_set[B_RSTOK]  = restart_ok_i;
    s2_set[B_OOR]    = oor_set_i;
    s1_live          = '0;
    s1_live[0]       = int_fault_i;
    a2_live          = '0;
    a2_live[0]       = fan_fault_i;
  end

  sa_flag_bank #(.W(BYTE_W), .LIVE_MASK(S2_LIVE_MASK), .RD_KEEP(S2_RD_KEEP),
                 .HOLD_MASK(S2_HOLD_MASK)) u_s2 (
    .clk(clk), .rst_n(rst_s), .live_i(s2_live), .set_i(s2_set),
    .clr_i(clr_faults_i), .rd_i(read_done_i), .hold_i(oor_hold_i),
    .q_o(img_q.s2), .d_o(img_d.s2)
  );

  sa_flag_bank #(.W(BYTE_W), .LIVE_MASK(LOW_BIT_MASK), .RD_KEEP('0),
                 .HOLD_MASK('0)) u_s1 (
    .clk(clk), .rst_n(rst_s), .live_i(s1_live), .set_i('0),
    .clr_i(clr_faults_i), .rd_i(read_done_i), .hold_i(1'b0),
    .q_o(img_q.s1), .d_o(img_d.s1)
  );

  sa_flag_bank #(.W(BYTE_W), .LIVE_MASK(LOW_BIT_MASK), .RD_KEEP('0),
                 .HOLD_MASK('0)) u_a2 (
    .clk(clk), .rst_n(rst_s), .live_i(a2_live), .set_i('0),
    .clr_i(clr_faults_i), .rd_i(read_done_i), .hold_i(1'b0),
    .q_o(img_q.a2), .d_o(img_d.a2)
  );

  sa_flag_bank #(.W(BYTE_W), .LIVE_MASK(A1_LIVE_MASK), .RD_KEEP('0),
                 .HOLD_MASK('0)) u_a1 (
    .clk(clk), .rst_n(rst_s), .live_i(alm_live_i), .set_i('0),
    .clr_i(clr_faults_i), .rd_i(read_done_i), .hold_i(1'b0),
    .q_o(img_q.a1), .d_o(img_d.a1)
  );

  assign host_any = clr_faults_i | read_done_i | recycle_i;

  sa_change_det #(.W(IMG_W)) u_det (
    .clk(clk), .rst_n(rst_s), .img_i(img_q), .img_d_i(img_d),
    .host_i(host_any), .alert_o(alert_q)
  );

  assign alert_n_o = ~alert_q;
  assign sts2_o    = img_q.s2;
  assign sts1_o    = img_q.s1;
  assign alm2_o    = img_q.a2;
  assign alm1_o    = img_q.a1;
endmodule

// File: rtl/sa_alert_chk.sv
module sa_alert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_i,
  input logic        clr_i,
  input logic        rd_i,
  input logic        hold_i,
  input logic        alert_n_i,
  input logic [31:0] img_i
);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    host_i |=> alert_n_i);

  a_r5_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n_i && !host_i) |=> !alert_n_i);

  a_r5_change_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_i && !$past(host_i) && !$stable(img_i)) |=> !alert_n_i);

  a_r10_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (img_i[23:0] == 24'h0));

  a_r9_keep_pec: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !clr_i && img_i[31]) |=> img_i[31]);

  a_r9_keep_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !clr_i && img_i[29]) |=> img_i[29]);

  a_r10_oor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hold_i && img_i[25]) |=> img_i[25]);
endmodule

bind sa_alert_ctrl sa_alert_chk u_chk (
  .clk(clk), .rst_n(rst_s), .host_i(host_any), .clr_i(clr_faults_i),
  .rd_i(read_done_i), .hold_i(oor_hold_i), .alert_n_i(alert_n_o),
  .img_i(img_q)
);

// File: tb/sim_sa_alert_ctrl.sv
module sim_sa_alert_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] alm_live;
  logic       fan, intf, will, iso, enh, pec, bad, oor, hold, rok, clr, rd, rcy;
  logic       alert_n;
  logic [7:0] s2, s1, a2, a1;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  m_s2 = 8'h0, m_s1 = 8'h0, m_a2 = 8'h0, m_a1 = 8'h0;
  logic [31:0] m_snap = 32'h0;
  logic        m_alert = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .alm_live_i(alm_live), .fan_fault_i(fan),
    .int_fault_i(intf), .will_restart_i(will), .iso_fail_i(iso),
    .en_pin_hi_i(enh), .pec_err_i(pec), .bad_cmd_i(bad), .oor_set_i(oor),
    .oor_hold_i(hold), .restart_ok_i(rok), .clr_faults_i(clr),
    .read_done_i(rd), .recycle_i(rcy), .alert_n_o(alert_n),
    .sts2_o(s2), .sts1_o(s1), .alm2_o(a2), .alm1_o(a1)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one flag byte by the keep/clear rules of the requirements
  function automatic logic [7:0] f_bank(input logic [7:0] cur, live, lmask, evt,
                                        keep_rd, hold_m, input logic c, r, h);
    logic [7:0] v;
    v = cur;
    if (r) v = v & keep_rd;
    if (c) v = v & (h ? hold_m : 8'h00);
    v = v | evt;
    if (!c && !r) v = v | (live & lmask);
    return v;
  endfunction

  task automatic idle();
    alm_live = 8'h0; fan = 0; intf = 0; will = 0; iso = 0; enh = 0;
    pec = 0; bad = 0; oor = 0; rok = 0; clr = 0; rd = 0; rcy = 0;
  endtask

  task automatic cyc(input string tag);
    logic [7:0]  n2, n1, na2, na1;
    logic [31:0] cur, nimg;
    logic        host, nal;
    n2  = f_bank(m_s2, {1'b0, will, 2'b0, iso, 2'b0, enh}, 8'h49,
                 {pec, 1'b0, bad, 2'b0, rok, oor, 1'b0}, 8'hA2, 8'h02, clr, rd, hold);
    n1  = f_bank(m_s1, {7'b0, intf}, 8'h01, 8'h0, 8'h0, 8'h0, clr, rd, 1'b0);
    na2 = f_bank(m_a2, {7'b0, fan}, 8'h01, 8'h0, 8'h0, 8'h0, clr, rd, 1'b0);
    na1 = f_bank(m_a1, alm_live, 8'hBF, 8'h0, 8'h0, 8'h0, clr, rd, 1'b0);
    host = clr | rd | rcy;
    cur  = {m_s2, m_s1, m_a2, m_a1};
    nimg = {n2, n1, na2, na1};
    nal  = host ? 1'b0 : (m_alert | (cur != m_snap));
    @(negedge clk);
    chk(tag, "sts2", {24'h0, s2}, {24'h0, n2});
    chk(tag, "sts1", {24'h0, s1}, {24'h0, n1});
    chk(tag, "alm2", {24'h0, a2}, {24'h0, na2});
    chk(tag, "alm1", {24'h0, a1}, {24'h0, na1});
    chk(tag, "alert_n", {31'h0, alert_n}, {31'h0, ~nal});
    m_s2 = n2; m_s1 = n1; m_a2 = na2; m_a1 = na1; m_alert = nal;
    if (host) m_snap = nimg;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); hold = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "image", {s2, s1, a2, a1}, 32'h0);
    chk("R1", "alert_n", {31'h0, alert_n}, 32'h1);

    // R2 latch and hold, R5 alert follows change
    alm_live = 8'h01; cyc("R2");
    idle(); cyc("R2");
    chk("R2", "alm1 held", {24'h0, a1}, 32'h01);
    chk("R5", "alert_n low", {31'h0, alert_n}, 32'h0);
    cyc("R5");
    chk("R5", "alert_n stays", {31'h0, alert_n}, 32'h0);
    rd = 1; cyc("R6"); idle();
    chk("R6", "alert_n released", {31'h0, alert_n}, 32'h1);
    chk("R9", "alm1 wiped", {24'h0, a1}, 32'h0);

    // R2 bit 6 ignored
    alm_live = 8'h40; cyc("R2"); idle(); cyc("R2");
    chk("R2", "alm1 bit6", {24'h0, a1}, 32'h0);
    chk("R2", "no alert", {31'h0, alert_n}, 32'h1);

    // R8 persistent fault re-latches after clear
    alm_live = 8'h10; repeat (3) cyc("R8");
    clr = 1; cyc("R8"); clr = 0;
    chk("R8", "bit cleared", {24'h0, a1}, 32'h0);
    chk("R8", "alert released", {31'h0, alert_n}, 32'h1);
    cyc("R8");
    chk("R8", "bit back", {24'h0, a1}, 32'h10);
    cyc("R8");
    chk("R8", "alert again", {31'h0, alert_n}, 32'h0);
    idle(); rd = 1; cyc("R8"); idle();

    // R3 events, R9 read keep, R10 clear with hold
    pec = 1; bad = 1; oor = 1; rok = 1; cyc("R3"); idle(); cyc("R3");
    chk("R3", "sts2 events", {24'h0, s2}, 32'hA6);
    rd = 1; cyc("R9"); idle();
    chk("R9", "sts2 kept", {24'h0, s2}, 32'hA2);
    hold = 1; clr = 1; cyc("R10"); idle();
    chk("R10", "sts2 hold", {24'h0, s2}, 32'h02);
    hold = 0; clr = 1; cyc("R10"); idle();
    chk("R10", "sts2 wiped", {24'h0, s2}, 32'h00);

    // R3 live status bits
    will = 1; iso = 1; enh = 1; cyc("R3"); idle();
    chk("R3", "sts2 live", {24'h0, s2}, 32'h49);
    rd = 1; cyc("R3"); idle(); cyc("R3");
    chk("R3", "sts2 clean", {24'h0, s2}, 32'h00);

    // R4 fan and internal
    fan = 1; intf = 1; cyc("R4"); idle();
    chk("R4", "sts1", {24'h0, s1}, 32'h01);
    chk("R4", "alm2", {24'h0, a2}, 32'h01);
    rd = 1; cyc("R4"); idle();

    // R11 recycle releases only
    alm_live = 8'h80; cyc("R11"); idle(); cyc("R11");
    rcy = 1; cyc("R11"); idle();
    chk("R11", "alm1 kept", {24'h0, a1}, 32'h80);
    chk("R11", "alert released", {31'h0, alert_n}, 32'h1);
    cyc("R11");
    chk("R11", "alert quiet", {31'h0, alert_n}, 32'h1);

    // R7 host changes do not alert
    clr = 1; cyc("R7"); idle(); cyc("R7"); cyc("R7");
    chk("R7", "alert after clear", {31'h0, alert_n}, 32'h1);

    // R12 coincidences
    pec = 1; rd = 1; alm_live = 8'h04; cyc("R12"); idle();
    chk("R12", "pec kept", {24'h0, s2}, 32'h80);
    chk("R12", "live skipped", {24'h0, a1}, 32'h00);
    clr = 1; cyc("R12"); idle(); cyc("R12");

    // random traffic checked against the model
    for (int k = 0; k < 4000; k++) begin
      idle();
      if (($urandom % 12) == 0) alm_live = 8'($urandom);
      fan  = (($urandom % 30) == 0);
      intf = (($urandom % 30) == 0);
      will = (($urandom % 30) == 0);
      iso  = (($urandom % 30) == 0);
      enh  = (($urandom % 30) == 0);
      pec  = (($urandom % 20) == 0);
      bad  = (($urandom % 20) == 0);
      oor  = (($urandom % 20) == 0);
      rok  = (($urandom % 20) == 0);
      clr  = (($urandom % 25) == 0);
      rd   = (($urandom % 25) == 0);
      rcy  = (($urandom % 40) == 0);
      if (($urandom % 16) == 0) hold = ~hold;
      cyc("R12");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule